// File: doc/BRIEF.md
# Byte-wide bus-mapped LIFO stack

This block gives an 8-bit processor a hardware last-in-first-out store with no pointer for software to manage. It answers at two neighbouring bus locations. Writing the data location pushes the byte. Reading the data location returns the current top byte, and that byte is removed when the read strobe ends. A 16-bit value therefore travels as two byte pushes and comes back as two byte pops. The second location is a status word that reports how full the stack is. Writing that location with its lowest bit set empties the stack.

The storage comes in two forms, chosen by a parameter. One is a small RAM indexed by an up/down pointer. The other is a chain of registers that shifts toward the top on a push and away from it on a pop. Both forms behave the same at the bus. Depth is a parameter and defaults to 16 entries. A 4-entry build is also supported. Misuse is recorded in two sticky error outputs: a push onto a full stack, and a pop from an empty one.

Top module: `mmio_lifo`

## Requirements
- R1: A write access with `addr`=0 pushes `wdata` onto the stack as the new top entry.
- R2: While a read access with `addr`=0 is active, `rdata` shows the top entry. The stack then gives up that entry, so successive reads return bytes in the reverse order of their pushes.
- R3: A push while the stack holds DEPTH entries is discarded and leaves the stored contents unchanged. It also sets `err_overflow`, which stays set until a clear or a reset.
- R4: A read with `addr`=0 on an empty stack returns 0x00 and leaves the count at zero. It also sets `err_underflow`, which stays set until a clear or a reset.
- R5: Each access performs exactly one operation, however many clocks its strobe lasts. A read pops once, on the clock edge where the strobe is first seen low. A write pushes once, on the edge where the strobe is first seen high.
- R6: A read with `addr`=1 returns a status byte and does not change the stack. The entry count sits in bits 5:0, bit 6 is 1 when the stack is empty, and bit 7 is 1 when it is full. An empty stack reads 0x40, and a full 16-entry stack reads 0x90.
- R7: A write with `addr`=1 and `wdata[0]`=1 empties the stack and clears both error outputs. The same write with `wdata[0]`=0 changes nothing.
- R8: When a pop and a push fall on the same edge, the top entry is replaced and the count is kept. On a full stack this raises no overflow. On an empty stack, underflow is flagged and the pushed byte becomes the only entry.
- R9: When a clear and a pop fall on the same edge, the clear wins: the stack ends empty and both flags are cleared.
- R10: Asserting `rst_n` low empties the stack and clears both error outputs. Release of the reset is synchronised to `clk`.
- R11: The shift-register form and the pointer-and-RAM form return identical `rdata` and flags for any sequence of accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select; qualifies `rd` and `wr` |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 1 | 0 selects the data location, 1 selects the status location |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data: top entry or status byte |
| err_overflow | output | 1 | Sticky flag: a push met a full stack |
| err_underflow | output | 1 | Sticky flag: a pop met an empty stack |

## Verification
A pop is committed when a read strobe ends, so it can share a clock edge with the first edge of the next write. That write can be a data push or a clear through the status location. The bench provokes this by dropping `rd` and raising `wr` at the same falling edge. It does this on a partly filled stack, a full stack and an empty stack, and once with a clear in place of the push. Each outcome is judged afterwards through status reads, the flag outputs and the order of the following pops, always on both storage forms.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // one-cycle operation strobes produced by the bus decoder
  typedef struct packed {
    logic push;
    logic pop;
    logic clr;
  } lifo_op_t;

endpackage

// File: rtl/lifo_bus_ctrl.sv
module lifo_bus_ctrl
  import lifo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs,
  input  logic     rd,
  input  logic     wr,
  input  logic     addr,
  input  logic     wbit0,
  output lifo_op_t op
);

  logic data_rd, data_wr, stat_wr;
  logic rd_q, dwr_q, swr_q;

  always_comb begin
    data_rd = cs & rd & ~wr & (addr == ADDR_DATA);
    data_wr = cs & wr & ~rd & (addr == ADDR_DATA);
    stat_wr = cs & wr & ~rd & (addr == ADDR_STAT);
    op.pop  = rd_q & ~data_rd;            // trailing edge of the read
    op.push = data_wr & ~dwr_q;           // leading edge of the write
    op.clr  = stat_wr & ~swr_q & wbit0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      dwr_q <= 1'b0;
      swr_q <= 1'b0;
    end else begin
      rd_q  <= data_rd;
      dwr_q <= data_wr;
      swr_q <= stat_wr;
    end
  end

  p_one_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op.pop |=> !op.pop);
  p_one_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op.push |=> !op.push);

endmodule

// File: rtl/lifo_ptr_store.sv
module lifo_ptr_store #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          do_push,
  input  logic          do_pop,
  input  logic [7:0]    wdata,
  output logic [CW-1:0] count,
  output logic [7:0]    top
);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] ptr, ptr_nxt;
  logic          we;
  logic [AW-1:0] widx;

  // ptr addresses the next free slot
  always_comb begin
    ptr_nxt = ptr;
    we      = 1'b0;
    widx    = AW'(ptr);
    if (clr) begin
      ptr_nxt = '0;
    end else begin
      unique case ({do_push, do_pop})
        2'b10: begin we = 1'b1; ptr_nxt = ptr + CW'(1); end
        2'b01: ptr_nxt = ptr - CW'(1);
        2'b11: begin we = 1'b1; widx = AW'(ptr - CW'(1)); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign count = ptr;
  assign top   = mem[AW'(ptr - CW'(1))];

  p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= CW'(DEPTH));

endmodule

// File: rtl/lifo_shift_store.sv
module lifo_shift_store #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          do_push,
  input  logic          do_pop,
  input  logic [7:0]    wdata,
  output logic [CW-1:0] count,
  output logic [7:0]    top
);

  logic [7:0]    ent     [DEPTH];
  logic [7:0]    ent_nxt [DEPTH];
  logic [CW-1:0] cnt, cnt_nxt;

  // entry 0 is always the top of stack
  always_comb begin
    for (int i = 0; i < DEPTH; i++) ent_nxt[i] = ent[i];
    cnt_nxt = cnt;
    if (clr) begin
      cnt_nxt = '0;
    end else if (do_push && do_pop) begin
      ent_nxt[0] = wdata;
    end else if (do_push) begin
      for (int i = 1; i < DEPTH; i++) ent_nxt[i] = ent[i-1];
      ent_nxt[0] = wdata;
      cnt_nxt    = cnt + CW'(1);
    end else if (do_pop) begin
      for (int i = 0; i < DEPTH - 1; i++) ent_nxt[i] = ent[i+1];
      ent_nxt[DEPTH-1] = 8'h00;
      cnt_nxt          = cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= 8'h00;
    end else begin
      cnt <= cnt_nxt;
      for (int i = 0; i < DEPTH; i++) ent[i] <= ent_nxt[i];
    end
  end

  assign count = cnt;
  assign top   = ent[0];

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/mmio_lifo.sv
module mmio_lifo
  import lifo_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter bit SHIFT_FORM = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       err_overflow,
  output logic       err_underflow
);

  // count must fit in the six low status bits
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]    rsync;
  logic          rst_i_n;
  lifo_op_t      op;
  logic [CW-1:0] count;
  logic [7:0]    top;
  logic          empty, full, do_push, do_pop;
  logic          ovf_q, ovf_nxt, unf_q, unf_nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i_n = rsync[1];

  lifo_bus_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .cs(cs), .rd(rd), .wr(wr),
    .addr(addr), .wbit0(wdata[0]), .op(op)
  );

  generate
    if (SHIFT_FORM) begin : g_shift
      lifo_shift_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_i_n), .clr(op.clr), .do_push(do_push),
        .do_pop(do_pop), .wdata(wdata), .count(count), .top(top)
      );
    end else begin : g_ptr
      lifo_ptr_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_i_n), .clr(op.clr), .do_push(do_push),
        .do_pop(do_pop), .wdata(wdata), .count(count), .top(top)
      );
    end
  endgenerate

  always_comb begin
    empty   = (count == '0);
    full    = (count == CW'(DEPTH));
    do_pop  = op.pop & ~op.clr & ~empty;
    do_push = op.push & ~op.clr & (~full | do_pop);
    ovf_nxt = op.clr ? 1'b0 : (ovf_q | (op.push & full & ~do_pop));
    unf_nxt = op.clr ? 1'b0 : (unf_q | (op.pop & empty));
    if (addr == ADDR_STAT) rdata = {full, empty, 6'(count)};
    else                   rdata = empty ? 8'h00 : top;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_nxt;
      unf_q <= unf_nxt;
    end
  end

  assign err_overflow  = ovf_q;
  assign err_underflow = unf_q;

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_overflow && !op.clr |=> err_overflow);
  p_full_push_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    op.push && full && !op.pop && !op.clr |=> $stable(count) && err_overflow);
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    op.pop && empty && !op.push && !op.clr |=> count == '0 && err_underflow);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    op.clr |=> count == '0 && !err_overflow && !err_underflow);
  p_swap_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    op.push && op.pop && !op.clr && !empty |=> $stable(count));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !op.clr |=> count == $past(count) || count == $past(count) + CW'(1)
             || count == $past(count) - CW'(1));

endmodule

// File: tb/mmio_lifo_bench.sv
`timescale 1ns/1ps
module mmio_lifo_bench;

  logic       clk, rst_n, cs, rd, wr, addr;
  logic [7:0] wdata;
  logic [7:0] rd_a, rd_b;
  logic       ovf_a, ovf_b, unf_a, unf_b;
  int n_chk, n_fail;

  mmio_lifo #(.DEPTH(16), .SHIFT_FORM(1'b0)) u_mmio_lifo (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rd_a), .err_overflow(ovf_a), .err_underflow(unf_a)
  );
  mmio_lifo #(.DEPTH(16), .SHIFT_FORM(1'b1)) u_mmio_lifo_shift (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rd_b), .err_overflow(ovf_b), .err_underflow(unf_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {is_read, addr, wdata, expected rdata}
  localparam logic [17:0] VEC [14] = '{
    {1'b0, 1'b0, 8'hA1, 8'h00}, {1'b0, 1'b0, 8'hB2, 8'h00},
    {1'b1, 1'b0, 8'h00, 8'hB2}, {1'b0, 1'b0, 8'hC3, 8'h00},
    {1'b1, 1'b0, 8'h00, 8'hC3}, {1'b1, 1'b1, 8'h00, 8'h01},
    {1'b1, 1'b0, 8'h00, 8'hA1}, {1'b1, 1'b1, 8'h00, 8'h40},
    {1'b1, 1'b0, 8'h00, 8'h00}, {1'b0, 1'b0, 8'h55, 8'h00},
    {1'b0, 1'b0, 8'h66, 8'h00}, {1'b1, 1'b1, 8'h00, 8'h02},
    {1'b1, 1'b0, 8'h00, 8'h66}, {1'b1, 1'b0, 8'h00, 8'h55}
  };

  task automatic chk(input string req, input logic [7:0] ga, input logic [7:0] gb,
                     input logic [7:0] exp);
    n_chk++;
    if (ga !== exp || gb !== exp) begin
      n_fail++;
      $display("FAIL %s: ptr form %h, shift form %h, expected %h", req, ga, gb, exp);
    end
  endtask

  task automatic idle();
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d, input int hold);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; rd = 1'b0; addr = a; wdata = d;
    repeat (hold) @(negedge clk);
    idle();
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] va, output logic [7:0] vb);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; wr = 1'b0; addr = a;
    #1 va = rd_a; vb = rd_b;
    @(negedge clk);
    idle();
    @(posedge clk); #1;
  endtask

  // read of the data location, then a write on the very next cycle
  task automatic rd_then_wr(input logic wa, input logic [7:0] d,
                            output logic [7:0] va, output logic [7:0] vb);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; wr = 1'b0; addr = 1'b0;
    #1 va = rd_a; vb = rd_b;
    @(negedge clk);
    rd = 1'b0; wr = 1'b1; addr = wa; wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic flags(input string req, input logic eo, input logic eu);
    chk(req, {6'b0, ovf_a, unf_a}, {6'b0, ovf_b, unf_b}, {6'b0, eo, eu});
  endtask

  initial begin
    int guard;
    guard = 0;
    while (guard < 20000) begin
      @(posedge clk);
      guard++;
    end
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a, b;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; addr = 1'b0; wdata = 8'h00;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    bus_rd(1'b1, a, b); chk("R10 status after reset", a, b, 8'h40);
    flags("R10 flags after reset", 1'b0, 1'b0);

    // table walk: R1 R2 R4 R6 R11
    for (int i = 0; i < 14; i++) begin
      if (!VEC[i][17]) begin
        bus_wr(VEC[i][16], VEC[i][15:8], 1);
      end else begin
        bus_rd(VEC[i][16], a, b);
        if (VEC[i][16]) chk("R6 status read", a, b, VEC[i][7:0]);
        else if (VEC[i][7:0] == 8'h00) chk("R4 empty pop data", a, b, 8'h00);
        else chk("R1/R2 LIFO order R11", a, b, VEC[i][7:0]);
      end
    end
    flags("R4 underflow sticky", 1'b0, 1'b1);
    bus_rd(1'b1, a, b); chk("R4 count unchanged", a, b, 8'h40);
    bus_wr(1'b1, 8'h01, 1);
    flags("R7 clear flags", 1'b0, 1'b0);

    // R3 overflow
    for (int i = 1; i <= 16; i++) bus_wr(1'b0, 8'(i), 1);
    bus_rd(1'b1, a, b); chk("R6 full status", a, b, 8'h90);
    flags("R3 no flag before overflow", 1'b0, 1'b0);
    bus_wr(1'b0, 8'hEE, 1);
    flags("R3 overflow set", 1'b1, 1'b0);
    bus_rd(1'b1, a, b); chk("R3 count kept", a, b, 8'h90);

    // R8 coincident pop and push on a full stack
    rd_then_wr(1'b0, 8'hAB, a, b); chk("R8 full read data", a, b, 8'h10);
    bus_rd(1'b1, a, b); chk("R8 full count kept", a, b, 8'h90);
    bus_rd(1'b0, a, b); chk("R8 replaced top", a, b, 8'hAB);
    bus_rd(1'b0, a, b); chk("R3 discarded byte absent", a, b, 8'h0F);
    flags("R3 overflow stays set", 1'b1, 1'b0);

    // R9 clear coincident with a pop
    rd_then_wr(1'b1, 8'h01, a, b); chk("R9 read data", a, b, 8'h0E);
    bus_rd(1'b1, a, b); chk("R9 empty after clear", a, b, 8'h40);
    flags("R9 flags cleared", 1'b0, 1'b0);

    // R8 coincident on an empty stack
    rd_then_wr(1'b0, 8'h5A, a, b); chk("R8 empty read data", a, b, 8'h00);
    flags("R8 underflow then push", 1'b0, 1'b1);
    bus_rd(1'b1, a, b); chk("R8 one entry", a, b, 8'h01);
    bus_wr(1'b1, 8'h01, 1);

    // R8 coincident on a partial stack
    bus_wr(1'b0, 8'h11, 1); bus_wr(1'b0, 8'h22, 1);
    rd_then_wr(1'b0, 8'h33, a, b); chk("R8 partial read data", a, b, 8'h22);
    bus_rd(1'b1, a, b); chk("R8 partial count", a, b, 8'h02);

    // R7 write without bit 0 has no effect
    bus_wr(1'b1, 8'hFE, 1);
    bus_rd(1'b1, a, b); chk("R7 no clear on bit0=0", a, b, 8'h02);

    // R5 held read pops once
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1 chk("R5 held read data", rd_a, rd_b, 8'h33);
      @(negedge clk);
    end
    idle();
    @(posedge clk); #1;
    bus_rd(1'b1, a, b); chk("R5 single pop", a, b, 8'h01);

    // R5 held write pushes once
    bus_wr(1'b0, 8'h44, 3);
    bus_rd(1'b1, a, b); chk("R5 single push", a, b, 8'h02);
    bus_rd(1'b0, a, b); chk("R5 pushed byte", a, b, 8'h44);
    bus_rd(1'b0, a, b); chk("R5 entry below", a, b, 8'h11);

    // R10 reset mid-run clears stack and flags
    bus_rd(1'b0, a, b);
    bus_wr(1'b0, 8'h77, 1); bus_wr(1'b0, 8'h78, 1);
    @(negedge clk); rst_n = 1'b0;
    #1 flags("R10 flags cleared by reset", 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(1'b1, a, b); chk("R10 empty after reset", a, b, 8'h40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule